// File: doc/BRIEF.md
# 64-bit Integer Execute Unit with Word Operations

This block is the integer execute stage of a 64-bit pipeline. It receives two register operands, a 12-bit immediate, a 20-bit upper immediate, the instruction address and a 5-bit operation select. It computes add, subtract, bitwise logic, signed and unsigned set-less-than, three kinds of shift, and upper-immediate forming, both plain and relative to the instruction address. It also provides 32-bit "word" forms of add, subtract and the shifts. These forms read only the low half of each operand and return a 32-bit result sign-extended to 64 bits.

A single `use_imm_i` strobe replaces the second operand with the sign-extended 12-bit immediate. The same select then covers register-immediate forms such as add-immediate, add-immediate-word and the constant shifts, whose shift amount comes from the low bits of the immediate. The result is registered once, so it appears on `result_o` one clock after the operands are presented.

Top module: `int_exec_unit`

## Requirements
- R1: ADD (code 0) and SUB (code 1) return the 64-bit sum or difference modulo 2^64. When `use_imm_i` is 1, the second operand is `imm_i` sign-extended from bit 11 to 64 bits.
- R2: ADDW (10), SUBW (11), SLLW (12), SRLW (13) and SRAW (14) use only bits 31:0 of the first operand. Their result is a 32-bit value sign-extended from bit 31, so output bits 63:31 are all equal.
- R3: ADDW and SUBW drop overflow out of bit 31. ADDW with `use_imm_i`=1 and a zero immediate yields bits 31:0 of the first operand sign-extended.
- R4: AND (2), OR (3) and XOR (4) are bitwise over all 64 bits.
- R5: SLT (5) compares as signed and SLTU (6) compares as unsigned, both over 64 bits. The result is 1 when the first operand is less than the second, otherwise 0.
- R6: SLL (7), SRL (8) and SRA (9) shift the first operand by bits 5:0 of the second operand. SLL and SRL fill with zeros. SRA fills with copies of bit 63.
- R7: The word shifts take their amount from bits 4:0 of the second operand. SRLW fills with zeros above bit 31 before sign extension. SRAW fills with copies of bit 31.
- R8: LUI (15) returns `uimm_i` in bits 31:12 with bits 11:0 cleared, sign-extended from bit 31.
- R9: AUIPC (16) returns `pc_i` plus the same sign-extended value LUI forms, modulo 2^64.
- R10: Select codes 17 to 31 produce a zero result.
- R11: While `rst_ni` is low, `result_o` is 0. After reset, the result for inputs sampled at one rising edge of `clk_i` is on `result_o` right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 5 | Operation select code |
| a_i | input | 64 | First operand |
| b_i | input | 64 | Second operand (register) |
| imm_i | input | 12 | Short immediate, sign-extended |
| use_imm_i | input | 1 | Use the immediate as the second operand |
| uimm_i | input | 20 | Upper immediate for LUI and AUIPC |
| pc_i | input | 64 | Address of the instruction |
| result_o | output | 64 | Registered result |

## Verification
The bench puts garbage in the upper operand halves for word operations. A design that leaks those bits returns a value that is not sign-extended. Overflow at bit 31 on ADDW, a shift of 31 on SLLW, and SRAW with bit 31 set would each show a missing or wrong sign extension. Shift amounts of 0x41 and 0x21 check the 6-bit and 5-bit masks; a design that uses too many bits would return zero. The bench also checks the signed/unsigned split of set-less-than with operands -1 and 1, the top and bottom of the upper-immediate range, an AUIPC that wraps to zero, and unused codes, which a sloppy decoder would route to some other result.

// File: rtl/int_exec_pkg.sv
package int_exec_pkg;
  typedef enum logic [4:0] {
    OP_ADD   = 5'd0,
    OP_SUB   = 5'd1,
    OP_AND   = 5'd2,
    OP_OR    = 5'd3,
    OP_XOR   = 5'd4,
    OP_SLT   = 5'd5,
    OP_SLTU  = 5'd6,
    OP_SLL   = 5'd7,
    OP_SRL   = 5'd8,
    OP_SRA   = 5'd9,
    OP_ADDW  = 5'd10,
    OP_SUBW  = 5'd11,
    OP_SLLW  = 5'd12,
    OP_SRLW  = 5'd13,
    OP_SRAW  = 5'd14,
    OP_LUI   = 5'd15,
    OP_AUIPC = 5'd16
  } alu_op_e;

  typedef enum logic [1:0] {
    SH_LL = 2'd0,
    SH_RL = 2'd1,
    SH_RA = 2'd2
  } sh_kind_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2
  } lg_kind_e;
endpackage

// File: rtl/iex_addsub.sv
module iex_addsub #(
  parameter int XLEN = 64,
  parameter int WORD = 32
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic            sub_i,
  input  logic            word_i,
  output logic [XLEN-1:0] res_o
);
  logic [XLEN-1:0] b_eff;
  logic [XLEN-1:0] sum;

  assign b_eff = sub_i ? ~b_i : b_i;
  assign sum   = a_i + b_eff + {{(XLEN-1){1'b0}}, sub_i};
  // low word of the full sum equals the 32-bit sum; carry above is dropped
  assign res_o = word_i ? {{(XLEN-WORD){sum[WORD-1]}}, sum[WORD-1:0]} : sum;
endmodule

// File: rtl/iex_shift.sv
module iex_shift
  import int_exec_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int WORD = 32
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  sh_kind_e        kind_i,
  input  logic            word_i,
  output logic [XLEN-1:0] res_o
);
  localparam int SH_W  = $clog2(XLEN);
  localparam int WSH_W = $clog2(WORD);

  logic [SH_W-1:0]  sh_d;
  logic [WSH_W-1:0] sh_w;
  logic [WORD-1:0]  a_w;
  logic [XLEN-1:0]  d_res;
  logic [WORD-1:0]  w_res;

  assign sh_d = b_i[SH_W-1:0];
  assign sh_w = b_i[WSH_W-1:0];
  assign a_w  = a_i[WORD-1:0];

  always_comb begin
    unique case (kind_i)
      SH_RL:   begin d_res = a_i >> sh_d; w_res = a_w >> sh_w; end
      SH_RA:   begin d_res = $signed(a_i) >>> sh_d; w_res = $signed(a_w) >>> sh_w; end
      default: begin d_res = a_i << sh_d; w_res = a_w << sh_w; end
    endcase
  end

  assign res_o = word_i ? {{(XLEN-WORD){w_res[WORD-1]}}, w_res} : d_res;
endmodule

// File: rtl/iex_logic_cmp.sv
module iex_logic_cmp
  import int_exec_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  lg_kind_e        kind_i,
  input  logic            unsigned_i,
  output logic [XLEN-1:0] logic_o,
  output logic [XLEN-1:0] lt_o
);
  logic lt;

  always_comb begin
    unique case (kind_i)
      LG_OR:   logic_o = a_i | b_i;
      LG_XOR:  logic_o = a_i ^ b_i;
      default: logic_o = a_i & b_i;
    endcase
  end

  assign lt   = unsigned_i ? (a_i < b_i) : ($signed(a_i) < $signed(b_i));
  assign lt_o = {{(XLEN-1){1'b0}}, lt};
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import int_exec_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int WORD   = 32,
  parameter int IMM_W  = 12,
  parameter int UIMM_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [4:0]        op_i,
  input  logic [XLEN-1:0]   a_i,
  input  logic [XLEN-1:0]   b_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              use_imm_i,
  input  logic [UIMM_W-1:0] uimm_i,
  input  logic [XLEN-1:0]   pc_i,
  output logic [XLEN-1:0]   result_o
);
  localparam int LOW_W = WORD - UIMM_W;

  alu_op_e         op;
  logic [XLEN-1:0] opb;
  logic [XLEN-1:0] upper;
  logic [XLEN-1:0] add_a, add_b;
  logic            add_sub, add_word;
  logic [XLEN-1:0] add_res, sh_res, lg_res, lt_res;
  sh_kind_e        sh_kind;
  logic            sh_word;
  lg_kind_e        lg_kind;
  logic [XLEN-1:0] res_d, res_q;
  logic [4:0]      op_q;

  assign op    = alu_op_e'(op_i);
  assign opb   = use_imm_i ? {{(XLEN-IMM_W){imm_i[IMM_W-1]}}, imm_i} : b_i;
  assign upper = {{(XLEN-WORD){uimm_i[UIMM_W-1]}}, uimm_i, {LOW_W{1'b0}}};

  // AUIPC shares the adder
  assign add_a    = (op == OP_AUIPC) ? pc_i  : a_i;
  assign add_b    = (op == OP_AUIPC) ? upper : opb;
  assign add_sub  = (op == OP_SUB) || (op == OP_SUBW);
  assign add_word = (op == OP_ADDW) || (op == OP_SUBW);

  always_comb begin
    unique case (op)
      OP_SRL, OP_SRLW: sh_kind = SH_RL;
      OP_SRA, OP_SRAW: sh_kind = SH_RA;
      default:         sh_kind = SH_LL;
    endcase
    unique case (op)
      OP_OR:   lg_kind = LG_OR;
      OP_XOR:  lg_kind = LG_XOR;
      default: lg_kind = LG_AND;
    endcase
  end
  assign sh_word = (op == OP_SLLW) || (op == OP_SRLW) || (op == OP_SRAW);

  iex_addsub #(.XLEN(XLEN), .WORD(WORD)) u_addsub (
    .a_i(add_a), .b_i(add_b), .sub_i(add_sub), .word_i(add_word), .res_o(add_res)
  );

  iex_shift #(.XLEN(XLEN), .WORD(WORD)) u_shift (
    .a_i(a_i), .b_i(opb), .kind_i(sh_kind), .word_i(sh_word), .res_o(sh_res)
  );

  iex_logic_cmp #(.XLEN(XLEN)) u_lgc (
    .a_i(a_i), .b_i(opb), .kind_i(lg_kind), .unsigned_i(op == OP_SLTU),
    .logic_o(lg_res), .lt_o(lt_res)
  );

  always_comb begin
    unique case (op)
      OP_ADD, OP_SUB, OP_ADDW, OP_SUBW, OP_AUIPC: res_d = add_res;
      OP_AND, OP_OR, OP_XOR:                      res_d = lg_res;
      OP_SLT, OP_SLTU:                            res_d = lt_res;
      OP_SLL, OP_SRL, OP_SRA,
      OP_SLLW, OP_SRLW, OP_SRAW:                  res_d = sh_res;
      OP_LUI:                                     res_d = upper;
      default:                                    res_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '0;
      op_q  <= '0;
    end else begin
      res_q <= res_d;
      op_q  <= op_i;
    end
  end

  assign result_o = res_q;

  p_word_sext_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_q inside {5'd10, 5'd11, 5'd12, 5'd13, 5'd14}) |->
      ((&res_q[XLEN-1:WORD-1]) || !(|res_q[XLEN-1:WORD-1])));

  p_lt_bool_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_q == 5'd5 || op_q == 5'd6) |-> (res_q[XLEN-1:1] == '0));

  p_lui_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_q == 5'd15) |-> (res_q[LOW_W-1:0] == '0));

  p_unused_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_q > 5'd16) |-> (res_q == '0));
endmodule

// File: tb/sim_int_exec_unit.sv
module sim_int_exec_unit;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  op = '0;
  logic [63:0] a = '0, b = '0, pc = '0;
  logic [11:0] imm = '0;
  logic        use_imm = 1'b0;
  logic [19:0] uimm = '0;
  logic [63:0] result;

  int checks = 0;
  int errors = 0;
  logic [63:0] exp_q[$];
  string       tag_q[$];
  bit          done = 1'b0;

  always #5 clk = ~clk;

  int_exec_unit u0 (
    .clk_i(clk), .rst_ni(rst_ni), .op_i(op), .a_i(a), .b_i(b), .imm_i(imm),
    .use_imm_i(use_imm), .uimm_i(uimm), .pc_i(pc), .result_o(result)
  );

  task automatic drive(input logic [4:0] o, input logic [63:0] ra, input logic [63:0] rb,
                       input logic [11:0] im, input logic ui, input logic [19:0] u,
                       input logic [63:0] p, input logic [63:0] expv, input string tag);
    @(negedge clk);
    op = o; a = ra; b = rb; imm = im; use_imm = ui; uimm = u; pc = p;
    exp_q.push_back(expv);
    tag_q.push_back(tag);
  endtask

  // monitor: result of inputs driven at the previous negedge lands at this posedge
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [63:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (result !== e) begin
        errors++;
        $display("FAIL %s: got %h expected %h", t, result, e);
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (result !== 64'd0) begin
      errors++;
      $display("FAIL R11 reset: got %h expected %h", result, 64'd0);
    end
    rst_ni = 1'b1;

    // R1
    drive(5'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 12'd0, 0, 0, 0, 64'd0, "R1 add wrap");
    drive(5'd1, 64'd5, 64'd7, 12'd0, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFE, "R1 sub");
    drive(5'd0, 64'd10, 64'd99, 12'hFFF, 1, 0, 0, 64'd9, "R1 add imm -1");
    // R2 / R3
    drive(5'd10, 64'hDEAD_BEEF_0000_0005, 64'h1234_5678_0000_0003, 12'd0, 0, 0, 0,
          64'd8, "R2 addw ignores upper");
    drive(5'd10, 64'h0000_0000_7FFF_FFFF, 64'd1, 12'd0, 0, 0, 0,
          64'hFFFF_FFFF_8000_0000, "R3 addw overflow");
    drive(5'd10, 64'h0000_0001_8000_0000, 64'd77, 12'd0, 1, 0, 0,
          64'hFFFF_FFFF_8000_0000, "R3 addiw zero sext");
    drive(5'd11, 64'hAAAA_0000_0000_0000, 64'd1, 12'd0, 0, 0, 0,
          64'hFFFF_FFFF_FFFF_FFFF, "R2 subw");
    // R4
    drive(5'd2, 64'hF0F0, 64'hFF00, 12'd0, 0, 0, 0, 64'hF000, "R4 and");
    drive(5'd3, 64'hF0F0, 64'hFF00, 12'd0, 0, 0, 0, 64'hFFF0, "R4 or");
    drive(5'd4, 64'hF0F0, 64'hFF00, 12'd0, 0, 0, 0, 64'h0FF0, "R4 xor");
    // R5
    drive(5'd5, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 12'd0, 0, 0, 0, 64'd1, "R5 slt signed");
    drive(5'd6, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 12'd0, 0, 0, 0, 64'd0, "R5 sltu unsigned");
    drive(5'd6, 64'd1, 64'hFFFF_FFFF_FFFF_FFFF, 12'd0, 0, 0, 0, 64'd1, "R5 sltu true");
    // R6
    drive(5'd7, 64'd1, 64'h41, 12'd0, 0, 0, 0, 64'd2, "R6 sll mask 6 bits");
    drive(5'd9, 64'h8000_0000_0000_0000, 64'd63, 12'd0, 0, 0, 0,
          64'hFFFF_FFFF_FFFF_FFFF, "R6 sra 63");
    drive(5'd8, 64'h8000_0000_0000_0000, 64'd63, 12'd0, 0, 0, 0, 64'd1, "R6 srl 63");
    drive(5'd9, 64'h8000_0000_0000_0000, 64'd0, 12'h403, 1, 0, 0,
          64'hF000_0000_0000_0000, "R6 sra imm 3");
    // R7
    drive(5'd12, 64'hFFFF_0000_0000_0001, 64'd31, 12'd0, 0, 0, 0,
          64'hFFFF_FFFF_8000_0000, "R7 sllw 31");
    drive(5'd13, 64'h0000_0000_8000_0000, 64'h21, 12'd0, 0, 0, 0,
          64'h0000_0000_4000_0000, "R7 srlw mask 5 bits");
    drive(5'd13, 64'h0000_0000_8000_0000, 64'd0, 12'd0, 0, 0, 0,
          64'hFFFF_FFFF_8000_0000, "R7 srlw 0 sext");
    drive(5'd14, 64'h0000_0000_8000_0000, 64'd4, 12'd0, 0, 0, 0,
          64'hFFFF_FFFF_F800_0000, "R7 sraw bit31 fill");
    // R8
    drive(5'd15, 0, 0, 12'd0, 0, 20'h80000, 0, 64'hFFFF_FFFF_8000_0000, "R8 lui neg");
    drive(5'd15, 0, 0, 12'd0, 0, 20'h12345, 0, 64'h0000_0000_1234_5000, "R8 lui pos");
    // R9
    drive(5'd16, 0, 0, 12'd0, 0, 20'hFFFFF, 64'h1000, 64'd0, "R9 auipc wrap");
    drive(5'd16, 0, 0, 12'd0, 0, 20'h00001, 64'h4000, 64'h5000, "R9 auipc");
    // R10
    drive(5'd17, 64'd3, 64'd4, 12'd0, 0, 20'h1, 64'h10, 64'd0, "R10 code 17");
    drive(5'd31, 64'd3, 64'd4, 12'd0, 0, 20'h1, 64'h10, 64'd0, "R10 code 31");
    // R11 back-to-back: each result valid exactly one edge later
    drive(5'd0, 64'd3, 64'd4, 12'd0, 0, 0, 0, 64'd7, "R11 latency a");
    drive(5'd0, 64'd30, 64'd40, 12'd0, 0, 0, 0, 64'd70, "R11 latency b");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule